// File: doc/BRIEF.md
# CRC4 Sync Search Counter

This block measures how long a framer has spent hunting for CRC4 multiframe alignment. A frame-rate tick (one per 125 µs frame) advances an internal search timer. The timer runs only while the CRC4 search is active and CRC4 mode is on. When it has seen 64 ticks, which is 8 ms, it expires. Each expiry advances a 6-bit count of failed search windows.

The count returns to zero when CRC4 alignment is acquired or when CRC4 mode is turned off. Otherwise it rolls over from 63 to 0. An abandon flag is raised once the count reaches 50 windows, about 400 ms. At that point the framer should give up the CRC4 search.

The block also packs an 8-bit status byte for a register file elsewhere. The byte holds five of the count bits and the three search-active flags.

Top module: `crc4_sync_search_ctr`

## Requirements
- R1: After reset, `count_o` is 0 and `abandon_o` is 0.
- R2: The search timer advances only on cycles with `frame_tick_i` high, and only while `crc_srch_i` and `mode_en_i` are both high. It expires on the 64th such tick. Cycles without a tick do not advance it.
- R3: Each timer expiry increments `count_o` by one. The new value is visible in the cycle after the edge that consumed the 64th tick.
- R4: A high `crc_sync_i` clears `count_o` to 0 at the next edge and restarts the timer from zero.
- R5: While `mode_en_i` is low, `count_o` is held at 0 and the timer does not advance, whatever ticks arrive.
- R6: While `crc_srch_i` is low, `count_o` holds its value and the timer restarts. A partial 8 ms window is discarded.
- R7: The count wraps: an expiry at count 63 gives count 0.
- R8: A `crc_sync_i` pulse that arrives in the same cycle as a timer expiry wins: the count becomes 0, not count+1.
- R9: The status byte has this layout, with bit 7 first: `status_o[7:3]` = count bits {5,4,3,2,0}, `status_o[2]` = `fas_srch_i`, `status_o[1]` = `cas_srch_i`, `status_o[0]` = `crc_srch_i`. Count bit 1 is not shown.
- R10: `abandon_o` is high exactly when `count_o` is 50 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle pulse per 125 µs frame |
| mode_en_i | input | 1 | CRC4 mode enable; low clears the count |
| crc_srch_i | input | 1 | CRC4 multiframe search active |
| fas_srch_i | input | 1 | FAS-level search active |
| cas_srch_i | input | 1 | CAS multiframe search active |
| crc_sync_i | input | 1 | Pulse: CRC4 alignment acquired |
| count_o | output | 6 | Search timeout count |
| status_o | output | 8 | Packed synchronizer status byte |
| abandon_o | output | 1 | Count has reached the abandon limit |

## Verification
A timer expiry and a sync acquisition can fall in the same clock cycle. In that case one of them has to decide the count.

The bench first builds the count up to 2. It then runs 63 more ticks and drives the 64th tick together with `crc_sync_i`. In the next cycle the count must read 0, not 3. After that, 63 more ticks must leave the count at 0, and one further tick must bring it to 1. This shows the timer restarted from zero.

// File: rtl/crc4_srch_pkg.sv
package crc4_srch_pkg;
  localparam int unsigned CNT_W       = 6;
  localparam int unsigned WIN_TICKS   = 64;  // 8 ms at 125 us frames
  localparam int unsigned ABANDON_CNT = 50;  // ~400 ms

  typedef struct packed {
    logic [4:0] cnt_vis;  // count bits 5,4,3,2,0
    logic       fas;
    logic       cas;
    logic       crc;
  } sync_stat_t;
endpackage

// File: rtl/srch_win_timer.sv
module srch_win_timer #(
  parameter int unsigned TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] tmr_q;

  assign expire_o = run_i && tick_i && (tmr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tmr_q <= '0;
    else if (restart_i || !run_i) tmr_q <= '0;
    else if (expire_o)           tmr_q <= '0;
    else if (tick_i)             tmr_q <= tmr_q + TW'(1);
  end

  assert_idle_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> tmr_q == '0);
  assert_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i && !tick_i) |=> $stable(tmr_q));
  assert_expire_needs_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> tick_i);
endmodule

// File: rtl/srch_wrap_counter.sv
module srch_wrap_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;   // clear beats increment
    else if (inc_i)  cnt_q <= cnt_q + W'(1);  // natural wrap
  end

  assign cnt_o = cnt_q;

  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == '1) |=> cnt_q == '0);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/srch_stat_pack.sv
module srch_stat_pack
  import crc4_srch_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] cnt_i,
  input  logic         fas_i,
  input  logic         cas_i,
  input  logic         crc_i,
  output logic [7:0]   stat_o
);
  sync_stat_t st;

  always_comb begin
    st.cnt_vis = {cnt_i[5], cnt_i[4], cnt_i[3], cnt_i[2], cnt_i[0]};
    st.fas     = fas_i;
    st.cas     = cas_i;
    st.crc     = crc_i;
    stat_o     = st;
  end
endmodule

// File: rtl/crc4_sync_search_ctr.sv
module crc4_sync_search_ctr
  import crc4_srch_pkg::*;
#(
  parameter int unsigned WIN   = WIN_TICKS,
  parameter int unsigned LIMIT = ABANDON_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_tick_i,
  input  logic             mode_en_i,
  input  logic             crc_srch_i,
  input  logic             fas_srch_i,
  input  logic             cas_srch_i,
  input  logic             crc_sync_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       status_o,
  output logic             abandon_o
);
  logic run, expire, clr;

  assign run = crc_srch_i && mode_en_i;
  assign clr = crc_sync_i || !mode_en_i;

  srch_win_timer #(.TICKS(WIN)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (frame_tick_i),
    .run_i    (run),
    .restart_i(crc_sync_i),
    .expire_o (expire)
  );

  srch_wrap_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (expire),
    .clr_i (clr),
    .cnt_o (count_o)
  );

  srch_stat_pack #(.W(CNT_W)) u_pack (
    .cnt_i (count_o),
    .fas_i (fas_srch_i),
    .cas_i (cas_srch_i),
    .crc_i (crc_srch_i),
    .stat_o(status_o)
  );

  assign abandon_o = (count_o >= CNT_W'(LIMIT));

  assert_sync_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_sync_i |=> count_o == '0);
  assert_mode_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> count_o == '0);
  assert_no_expire_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |-> !expire);
endmodule

// File: tb/tb_crc4_sync_search_ctr.sv
module tb_crc4_sync_search_ctr;
  logic clk = 0, rst_n = 0;
  logic tick = 0, mode = 0, crc = 0, fas = 0, cas = 0, sync = 0;
  logic [5:0] count;
  logic [7:0] status;
  logic abandon;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  crc4_sync_search_ctr dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick), .mode_en_i(mode),
    .crc_srch_i(crc), .fas_srch_i(fas), .cas_srch_i(cas), .crc_sync_i(sync),
    .count_o(count), .status_o(status), .abandon_o(abandon)
  );

  // {timeouts, fas, cas, crc, expected status}
  localparam logic [17:0] VEC [0:6] = '{
    {7'd0,  1'b0, 1'b0, 1'b0, 8'h00},
    {7'd1,  1'b1, 1'b0, 1'b1, 8'h0D},
    {7'd2,  1'b0, 1'b1, 1'b0, 8'h02},
    {7'd3,  1'b1, 1'b1, 1'b1, 8'h0F},
    {7'd5,  1'b0, 1'b0, 1'b1, 8'h19},
    {7'd50, 1'b1, 1'b0, 1'b0, 8'hC4},
    {7'd63, 1'b0, 1'b1, 1'b1, 8'hFB}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      if (gap) begin @(negedge clk) tick = 0; end
    end
    @(negedge clk) tick = 0;
  endtask

  task automatic clear_by_mode();
    @(negedge clk) mode = 0;
    @(negedge clk) mode = 1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count == 0, "R1 count", count, 0);
    chk(abandon == 0, "R1 abandon", abandon, 0);
    rst_n = 1;

    // vector table: R3, R9, R10
    for (int v = 0; v < 7; v++) begin
      clear_by_mode();
      crc = 1; fas = 0; cas = 0;
      ticks(int'(VEC[v][17:11]) * 64, 0);
      crc = VEC[v][8]; fas = VEC[v][10]; cas = VEC[v][9];
      #1;
      chk(count == VEC[v][17:11], "R3 count", count, int'(VEC[v][17:11]));
      chk(status == VEC[v][7:0], "R9 status", status, int'(VEC[v][7:0]));
      chk(abandon == (VEC[v][17:11] >= 50), "R10 abandon", abandon, int'(VEC[v][17:11] >= 50));
    end

    // R2: gapped ticks, expiry on 64th tick only
    clear_by_mode(); crc = 1;
    ticks(63, 1);
    chk(count == 0, "R2 63 ticks", count, 0);
    ticks(1, 1);
    chk(count == 1, "R2 64th tick", count, 1);
    repeat (100) @(negedge clk);
    chk(count == 1, "R2 no tick no advance", count, 1);

    // R6: partial window discarded, count held
    ticks(40, 0);
    @(negedge clk) crc = 0;
    @(negedge clk) crc = 1;
    ticks(40, 0);
    chk(count == 1, "R6 hold and restart", count, 1);
    ticks(24, 0);
    chk(count == 2, "R6 full window after restart", count, 2);

    // R4: sync clears
    @(negedge clk) sync = 1;
    @(negedge clk) sync = 0;
    chk(count == 0, "R4 sync clear", count, 0);

    // R8: sync coincident with expiry
    clear_by_mode(); crc = 1;
    ticks(128, 0);
    chk(count == 2, "R8 setup", count, 2);
    ticks(63, 0);
    @(negedge clk) begin tick = 1; sync = 1; end
    @(negedge clk) begin tick = 0; sync = 0; end
    chk(count == 0, "R8 clear wins", count, 0);
    ticks(63, 0);
    chk(count == 0, "R4 timer restarted", count, 0);
    ticks(1, 0);
    chk(count == 1, "R4 first window after sync", count, 1);

    // R5: mode off clears and freezes
    @(negedge clk) mode = 0;
    ticks(200, 0);
    chk(count == 0, "R5 mode off", count, 0);
    @(negedge clk) mode = 1;
    ticks(63, 0);
    chk(count == 0, "R5 timer idle while off", count, 0);

    // R10 boundary and R7 wrap
    clear_by_mode();
    ticks(49 * 64, 0);
    chk(abandon == 0, "R10 at 49", abandon, 0);
    ticks(64, 0);
    chk(abandon == 1, "R10 at 50", abandon, 1);
    ticks(13 * 64, 0);
    chk(count == 63, "R7 at 63", count, 63);
    ticks(64, 0);
    chk(count == 0, "R7 wrap", count, 0);
    chk(abandon == 0, "R10 after wrap", abandon, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule